// File: doc/BRIEF.md
# Receive Width Adapter Gearbox

This block sits on the receive side of a serial link, between the link-side word stream and the core logic. It converts the link-side words back into fixed core words that are four symbols wide. The code on `widthSel` picks the mode at run time. In the high-rate mode (code 80), each wide link word of eight symbols is split into two core words. In the low-rate mode (code 20), two narrow link words of two symbols each are joined into one core word. Any other code is illegal: the block raises `errFlag` and discards its input.

The link-side and core-side clocks are derived from one source with zero frequency offset, and their ratio is 2:1 or 1:2 depending on the mode. For that reason the block runs on a single clock, the faster of the two. The slower side is marked by a valid strobe: `inValid` on the input, `outValid` on the output. Each half of a split, and each half-word of a join, is taken in the order that mirrors the transmit adapter, so a transmit-to-receive loopback returns the original core words.

The symbol width is a parameter: 8 bits for coded traffic, 10 for uncoded. With the default of 8, the widths are 16 bits (low-rate link), 32 bits (core) and 64 bits (high-rate link).

Top module: `rx_gearbox`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `outValid` and `errFlag` are 0.
- R2: With `widthSel` = 80, a word accepted on `inValid` at clock edge t shows bits [31:0] on `outData` with `outValid` = 1 after edge t. It then shows bits [63:32] with `outValid` = 1 after edge t+1.
- R3: With `widthSel` = 80, `inValid` at the edge right after an accepted word is ignored, because that slot carries the upper half. No output ever comes from that input.
- R4: With `widthSel` = 20, the first accepted half-word goes to `outData[15:0]` and the second to `outData[31:16]`. `outValid` = 1 after the edge that accepts the second half-word.
- R5: While `widthSel` stays 20, `outValid` is never high in two consecutive cycles.
- R6: A `widthSel` code other than 20 or 80 sets `errFlag` after the next edge, and `outValid` stays 0. Words offered under an illegal code never appear at the output.
- R7: The joining phase restarts at the first half-word after reset and after any change of `widthSel`. A half-word taken before the restart is dropped.
- R8: In low-rate mode only `inWord[15:0]` is used. The upper bits of `inWord` have no effect on `outData`.
- R9: In low-rate mode, cycles with `inValid` = 0 leave the joining phase unchanged, so half-words may arrive with gaps between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the faster of the two side rates |
| rst | input | 1 | Synchronous active-high reset |
| widthSel | input | 7 | Link width code: 80 = split, 20 = join, others illegal |
| inValid | input | 1 | Link-side word present on `inWord` |
| inWord | input | 64 | Link-side word; low-rate mode uses bits [15:0] |
| outValid | output | 1 | A completed core word is on `outData` |
| outData | output | 32 | Core-side word |
| errFlag | output | 1 | Registered flag for an illegal `widthSel` code |

## Verification
A stale pending-upper-half flag shows at the port within one cycle: either an extra core word carrying old upper bits, or a missing one. The scoreboard reports either case at the next compare or at the final drain. A joining phase that is off by one shows as swapped 16-bit halves on the very next joined word. It can also show as a word built from a half-word taken before a reset or a mode change. Both are caught by the first compare after the event. A wrong mode decode shows in the next cycle as `errFlag` disagreeing with the code, or as output appearing under an illegal code.

// File: rtl/rx_gearbox_pkg.sv
package rx_gearbox_pkg;
  localparam int SEL_W     = 7;
  localparam int CODE_HIGH = 80;
  localparam int CODE_LOW  = 20;

  typedef enum logic [1:0] {
    MODE_ILLEGAL = 2'd0,
    MODE_SPLIT   = 2'd1,
    MODE_JOIN    = 2'd2
  } gbMode_t;

  typedef struct packed {
    logic splitLoad;   // emit lower half of a wide word, hold upper half
    logic emitUpper;   // emit the held upper half
    logic joinStore;   // hold first narrow half-word
    logic joinEmit;    // emit held half-word joined with current one
  } gbStrobe_t;

  function automatic gbMode_t decodeMode(input logic [SEL_W-1:0] code);
    if (code == SEL_W'(CODE_HIGH))     return MODE_SPLIT;
    else if (code == SEL_W'(CODE_LOW)) return MODE_JOIN;
    else                               return MODE_ILLEGAL;
  endfunction
endpackage

// File: rtl/rx_gearbox_ctrl.sv
module rx_gearbox_ctrl
  import rx_gearbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] widthSel,
  input  logic             inValid,
  output gbStrobe_t        strobe,
  output logic             errFlag,
  output logic             pendingUpper
);
  gbMode_t modeNow;
  gbMode_t modePrev;
  logic    joinPhase;
  logic    restart;
  logic    effPending;
  logic    effPhase;
  logic    pendingNext;
  logic    phaseNext;

  assign modeNow    = decodeMode(widthSel);
  assign restart    = (modeNow != modePrev);
  assign effPending = pendingUpper & ~restart;
  assign effPhase   = joinPhase & ~restart;

  always_comb begin
    strobe      = '0;
    pendingNext = 1'b0;
    phaseNext   = 1'b0;
    unique case (modeNow)
      MODE_SPLIT: begin
        if (effPending) begin
          strobe.emitUpper = 1'b1;
        end else if (inValid) begin
          strobe.splitLoad = 1'b1;
          pendingNext      = 1'b1;
        end
      end
      MODE_JOIN: begin
        phaseNext = effPhase;
        if (inValid) begin
          if (effPhase) strobe.joinEmit  = 1'b1;
          else          strobe.joinStore = 1'b1;
          phaseNext = ~effPhase;
        end
      end
      default: begin
        strobe = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modePrev     <= MODE_ILLEGAL;
      joinPhase    <= 1'b0;
      pendingUpper <= 1'b0;
      errFlag      <= 1'b0;
    end else begin
      modePrev     <= modeNow;
      joinPhase    <= phaseNext;
      pendingUpper <= pendingNext;
      errFlag      <= (modeNow == MODE_ILLEGAL);
    end
  end
endmodule

// File: rtl/rx_gearbox_dp.sv
module rx_gearbox_dp
  import rx_gearbox_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  gbStrobe_t            strobe,
  input  logic [8*SYM_W-1:0]   inWord,
  output logic                 outValid,
  output logic [4*SYM_W-1:0]   outData
);
  localparam int CORE_W = 4 * SYM_W;
  localparam int WIDE_W = 8 * SYM_W;
  localparam int NARR_W = 2 * SYM_W;

  logic [CORE_W-1:0] upperHold;
  logic [NARR_W-1:0] lowHold;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      outData   <= '0;
      upperHold <= '0;
      lowHold   <= '0;
    end else begin
      outValid <= strobe.splitLoad | strobe.emitUpper | strobe.joinEmit;
      if (strobe.splitLoad) begin
        outData   <= inWord[CORE_W-1:0];
        upperHold <= inWord[WIDE_W-1:CORE_W];
      end else if (strobe.emitUpper) begin
        outData <= upperHold;
      end else if (strobe.joinEmit) begin
        outData <= {inWord[NARR_W-1:0], lowHold};
      end
      if (strobe.joinStore) begin
        lowHold <= inWord[NARR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/rx_gearbox.sv
module rx_gearbox
  import rx_gearbox_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEL_W-1:0]     widthSel,
  input  logic                 inValid,
  input  logic [8*SYM_W-1:0]   inWord,
  output logic                 outValid,
  output logic [4*SYM_W-1:0]   outData,
  output logic                 errFlag
);
  gbStrobe_t strobe;
  logic      pendingUpper;

  rx_gearbox_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .widthSel     (widthSel),
    .inValid      (inValid),
    .strobe       (strobe),
    .errFlag      (errFlag),
    .pendingUpper (pendingUpper)
  );

  rx_gearbox_dp #(.SYM_W(SYM_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .inWord   (inWord),
    .outValid (outValid),
    .outData  (outData)
  );
endmodule

// File: rtl/rx_gearbox_chk.sv
module rx_gearbox_chk
  import rx_gearbox_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [SEL_W-1:0] widthSel,
  input logic             outValid,
  input logic             errFlag,
  input logic             pendingUpper
);
  // R6: an illegal code never coexists with a produced word
  p_err_no_out_r6: assert property (@(posedge clk) disable iff (rst)
    !(errFlag && outValid));

  // R6: illegal code flagged one edge later
  p_err_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (widthSel != SEL_W'(CODE_HIGH) && widthSel != SEL_W'(CODE_LOW)) |=> errFlag);

  // R5: joined words never back to back
  p_join_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (outValid && widthSel == SEL_W'(CODE_LOW) && $past(widthSel) == SEL_W'(CODE_LOW))
      |=> !outValid);

  // R2: a held upper half always follows an emitted lower half
  p_split_pair_r2: assert property (@(posedge clk) disable iff (rst)
    pendingUpper |-> outValid);

  // R1: clean outputs right after reset
  p_reset_clean_r1: assert property (@(posedge clk)
    $fell(rst) |-> (!outValid && !errFlag));
endmodule

bind rx_gearbox rx_gearbox_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .widthSel     (widthSel),
  .outValid     (outValid),
  .errFlag      (errFlag),
  .pendingUpper (pendingUpper)
);

// File: tb/rx_gearbox_tb.sv
module rx_gearbox_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  widthSel = 7'd80;
  logic        inValid = 1'b0;
  logic [63:0] inWord = '0;
  logic        outValid;
  logic [31:0] outData;
  logic        errFlag;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] expQ[$];
  string curReq = "R2";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_gearbox u_dut (
    .clk(clk), .rst(rst), .widthSel(widthSel), .inValid(inValid),
    .inWord(inWord), .outValid(outValid), .outData(outData), .errFlag(errFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected words as outputs appear
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expQ.size() == 0) check(curReq, outData, 32'hxxxx_xxxx);
      else check(curReq, outData, expQ.pop_front());
    end
  end

  task automatic step(input logic v, input logic [63:0] d);
    @(posedge clk); #1;
    inValid = v; inWord = d;
  endtask

  task automatic setSel(input logic [6:0] code);
    @(posedge clk); #1;
    inValid = 1'b0; widthSel = code;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 64'hdead_beef_dead_beef);
  endtask

  // driver: wide word, expected lower then upper half (R2)
  task automatic sendWide(input logic [63:0] w);
    expQ.push_back(w[31:0]);
    expQ.push_back(w[63:32]);
    step(1'b1, w);
    step(1'b0, 64'h0);
  endtask

  task automatic drainCheck(input string req);
    idle(4);
    @(negedge clk);
    check(req, 32'(expQ.size()), 32'd0);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {30'd0, outValid, errFlag}, 32'd0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check("R1", {30'd0, outValid, errFlag}, 32'd0);

    // R2 split, several patterns incl. back-to-back streaming
    curReq = "R2";
    sendWide(64'h0123_4567_89ab_cdef);
    sendWide(64'hffff_0000_a5a5_5a5a);
    expQ.push_back(32'h1111_2222); expQ.push_back(32'h3333_4444);
    expQ.push_back(32'h5555_6666); expQ.push_back(32'h7777_8888);
    step(1'b1, 64'h3333_4444_1111_2222);
    step(1'b0, 64'h0);
    step(1'b1, 64'h7777_8888_5555_6666);
    step(1'b0, 64'h0);
    drainCheck("R2");

    // R3 second word in the upper-half slot is ignored
    curReq = "R3";
    expQ.push_back(32'hcafe_0001); expQ.push_back(32'hcafe_0002);
    step(1'b1, 64'hcafe_0002_cafe_0001);
    step(1'b1, 64'hbad0_bad0_bad0_bad0);
    step(1'b0, 64'h0);
    drainCheck("R3");

    // R4 join ordering, R8 upper bits ignored
    setSel(7'd20);
    curReq = "R4";
    expQ.push_back(32'hbbbb_aaaa);
    step(1'b1, 64'h0000_0000_0000_aaaa);
    step(1'b1, 64'h0000_0000_0000_bbbb);
    step(1'b0, 64'h0);
    drainCheck("R4");
    curReq = "R8";
    expQ.push_back(32'h2345_1234);
    step(1'b1, 64'hffff_ffff_ffff_1234);
    step(1'b1, 64'h9999_8888_7777_2345);
    // R5 continuous stream: every other cycle
    curReq = "R5";
    expQ.push_back(32'h0004_0003); expQ.push_back(32'h0006_0005);
    step(1'b1, 64'h3); step(1'b1, 64'h4); step(1'b1, 64'h5); step(1'b1, 64'h6);
    step(1'b0, 64'h0);
    drainCheck("R8");

    // R9 gaps hold the phase
    curReq = "R9";
    expQ.push_back(32'h00b2_00b1);
    step(1'b1, 64'hb1); idle(3); step(1'b1, 64'hb2); step(1'b0, 64'h0);
    drainCheck("R9");

    // R7 restart after reset
    curReq = "R7";
    step(1'b1, 64'hdd01);
    @(posedge clk); #1 rst = 1'b1; inValid = 1'b0;
    @(posedge clk); #1 rst = 1'b0;
    expQ.push_back(32'h00e2_00e1);
    step(1'b1, 64'he1); step(1'b1, 64'he2); step(1'b0, 64'h0);
    drainCheck("R7");
    // R7 restart after mode change
    step(1'b1, 64'hdd02);
    setSel(7'd80);
    setSel(7'd20);
    expQ.push_back(32'h00f2_00f1);
    step(1'b1, 64'hf1); step(1'b1, 64'hf2); step(1'b0, 64'h0);
    drainCheck("R7");

    // R6 illegal code
    curReq = "R6";
    setSel(7'd40);
    @(posedge clk); @(negedge clk);
    check("R6", {31'd0, errFlag}, 32'd1);
    step(1'b1, 64'h1234_5678_9abc_def0);
    step(1'b1, 64'h1111_1111_1111_1111);
    step(1'b0, 64'h0);
    drainCheck("R6");
    setSel(7'd80);
    @(posedge clk); @(negedge clk);
    check("R6", {31'd0, errFlag}, 32'd0);
    curReq = "R2";
    sendWide(64'h8765_4321_0fed_cba9);
    drainCheck("R2");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule